// File: doc/BRIEF.md
# Serial Acquisition Sequencer with Wrapping Word Buffer

This block runs the capture side of a converter chain. Each device in the chain has two integrating channels and shifts out its results serially. When the chain pulls its data-ready line low, the sequencer waits a programmable number of slow-clock periods. It then asserts its active-low transmit enable and clocks out twenty bits per channel, two channels per device, for as many devices as are configured. Each 20-bit result is framed into a 24-bit word with a side tag. The word is handed to an external byte-wide memory over three consecutive write cycles.

A 15-bit address pointer steps up after every stored word and wraps around, so the oldest entries are overwritten once the buffer is full. In readback mode the memory is never written, although the serial bursts still run. The pointer then moves down only when the host pulses a decrement request, so the newest word comes back first. A request to change mode takes effect only between events, so a burst never ends up half stored.

Top module: `acq_seq`

## Requirements
- R1: While and right after reset, `xmit_n` is 1, `dclk` is 0, `mem_we` is 0, `mem_addr` is 0, and the side tag of the first event is side A.
- R2: A falling edge of `dvalid_n` seen by the sequencer while it is idle makes `xmit_n` go low N×SCLK_DIV clock cycles later, where N is `dly_n`. A value of 0 is treated as 1.
- R3: Each event produces 2×D words of 20 `dclk` pulses each, where D is `dev_num`, a value of 0 is taken as 1 and values above 64 are taken as 64. Each pulse is high for one cycle and low for one cycle. `sdata` is taken at the clock edge where `dclk` falls, most significant bit first. `dclk` pulses only while `xmit_n` is low.
- R4: A stored word has the serial result in bits 19:0 and the side tag in bit 22 (1 = side A, 0 = side B). Bits 23, 21 and 20 are zero.
- R5: In collect mode, each word is written in three consecutive cycles with `mem_bsel` = 0, 1, 2, carrying word bits 7:0, 15:8 and 23:16. `mem_addr` is held over the three cycles and rises by one after the third.
- R6: The pointer wraps from 32767 to 0 when it increments and from 0 to 32767 when it decrements.
- R7: In readback mode (`collect` = 0), events still produce `dclk` bursts but never assert `mem_we`. A one-cycle `dec_req` pulse lowers `mem_addr` by one. In collect mode `dec_req` is ignored.
- R8: After a decrement in readback, `mem_addr` points at the most recently written word, and each further decrement points at the word written before it.
- R9: A change of `collect` during an event takes effect only after that event ends. All words of an event started in collect mode are stored.
- R10: The side tag starts at A and toggles once per event, in either mode.
- R11: `xmit_n` returns to 1 once the last word of an event has been received (and stored, in collect mode). Further falling edges of `dvalid_n` during an event are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| collect | input | 1 | 1 = capture into memory, 0 = readback |
| dvalid_n | input | 1 | Data-ready from the chain, active low, synchronous to clk |
| sdata | input | 1 | Serial data from the chain |
| dly_n | input | 9 | Delay before transmit enable, in slow-clock periods |
| dev_num | input | 7 | Number of chained devices |
| dec_req | input | 1 | Host pulse: step the pointer down (readback only) |
| xmit_n | output | 1 | Active-low transmit enable to the chain |
| dclk | output | 1 | Serial data clock to the chain |
| mem_addr | output | 15 | Word address (current pointer) |
| mem_wdata | output | 8 | Byte being written |
| mem_bsel | output | 2 | Byte lane of the current write |
| mem_we | output | 1 | Memory write strobe |

## Verification
Captures are run with results of all ones, a single set LSB, a single set MSB, alternating bits and arbitrary values. This separates bit-order and lane-order faults from a dropped edge bit, and the side tag is checked across consecutive events. Delay values of 0, 1 and 3 tell the clamp apart from an off-by-one period count. Device counts of 0, 1, 2 and 100 tell the clamps apart from the ordinary burst length. The readback part walks the pointer down through stored words and past zero, then captures across the top of the address range. This separates increment wrap, decrement wrap and newest-first ordering. A mode change and a repeated data-ready edge issued mid-event show that each is deferred or ignored.

// File: rtl/acq_pkg.sv
package acq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_DELAY = 2'd1,
      ST_SHIFT = 2'd2,
      ST_WRITE = 2'd3
   } acq_state_t;

endpackage

// File: rtl/acq_dly_timer.sv
// Counts N slow-clock periods after a start pulse; done is a one-cycle flag.
module acq_dly_timer #(
   parameter int DLY_W    = 9,
   parameter int SCLK_DIV = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [DLY_W-1:0] n_in,
   output logic             done
);
   localparam int PW = (SCLK_DIV > 1) ? $clog2(SCLK_DIV) : 1;

   logic             busy;
   logic             tick;
   logic [DLY_W-1:0] n_q;
   logic [DLY_W-1:0] sc;

   generate
      if (SCLK_DIV == 1) begin : g_direct
         assign tick = 1'b1;
      end else begin : g_prescale
         logic [PW-1:0] pc;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         pc <= '0;
            else if (start)     pc <= '0;
            else if (busy)      pc <= (pc == PW'(SCLK_DIV - 1)) ? '0 : pc + PW'(1);
         end
         assign tick = (pc == PW'(SCLK_DIV - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         n_q  <= DLY_W'(1);
         sc   <= '0;
      end else if (start) begin
         busy <= 1'b1;
         n_q  <= (n_in == '0) ? DLY_W'(1) : n_in;
         sc   <= '0;
      end else if (busy && tick) begin
         if (sc == n_q - DLY_W'(1)) busy <= 1'b0;
         else                       sc   <= sc + DLY_W'(1);
      end
   end

   assign done = busy && tick && (sc == n_q - DLY_W'(1));
endmodule

// File: rtl/acq_shifter.sv
// Serial clock generator and input shift register. Runs while run is high.
module acq_shifter #(
   parameter int DATA_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              sdata,
   output logic              dclk,
   output logic              word_done,
   output logic [DATA_W-1:0] data
);
   localparam int BW = $clog2(DATA_W);

   logic          ph;
   logic [BW-1:0] bcnt;
   logic          last_bit;

   assign last_bit = (bcnt == BW'(DATA_W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph   <= 1'b0;
         bcnt <= '0;
         data <= '0;
      end else if (!run) begin
         ph   <= 1'b0;
         bcnt <= '0;
      end else begin
         ph <= ~ph;
         if (ph) begin
            data <= {data[DATA_W-2:0], sdata};
            bcnt <= last_bit ? '0 : bcnt + BW'(1);
         end
      end
   end

   assign dclk      = ph;
   assign word_done = run && ph && last_bit;
endmodule

// File: rtl/acq_ptr.sv
// Wrapping up/down word pointer.
module acq_ptr #(
   parameter int PTR_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             dec,
   output logic [PTR_W-1:0] ptr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ptr <= '0;
      else if (inc) ptr <= ptr + PTR_W'(1);
      else if (dec) ptr <= ptr - PTR_W'(1);
   end
endmodule

// File: rtl/acq_seq.sv
module acq_seq
   import acq_pkg::*;
#(
   parameter int DATA_W     = 20,
   parameter int SIDE_BIT   = 22,
   parameter int PTR_W      = 15,
   parameter int DLY_W      = 9,
   parameter int DEV_W      = 7,
   parameter int DEV_MAX    = 64,
   parameter int CH_PER_DEV = 2,
   parameter int SCLK_DIV   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             collect,
   input  logic             dvalid_n,
   input  logic             sdata,
   input  logic [DLY_W-1:0] dly_n,
   input  logic [DEV_W-1:0] dev_num,
   input  logic             dec_req,
   output logic             xmit_n,
   output logic             dclk,
   output logic [PTR_W-1:0] mem_addr,
   output logic [7:0]       mem_wdata,
   output logic [1:0]       mem_bsel,
   output logic             mem_we
);
   localparam int WORD_W = ((SIDE_BIT + 1 + 7) / 8) * 8;
   localparam int LANES  = WORD_W / 8;
   localparam int WC_W   = $clog2(DEV_MAX * CH_PER_DEV + 1);

   generate
      if (SIDE_BIT < DATA_W) begin : g_bad_side
         $error("side tag position overlaps the data field");
      end
      if (LANES > 4) begin : g_bad_lanes
         $error("word needs more byte lanes than mem_bsel can select");
      end
      if (DEV_MAX >= (1 << DEV_W)) begin : g_bad_dev
         $error("DEV_MAX does not fit dev_num");
      end
      if (SCLK_DIV < 1) begin : g_bad_div
         $error("SCLK_DIV must be at least 1");
      end
   endgenerate

   acq_state_t       state;
   logic             dv_q;
   logic             fall;
   logic             mode_q;
   logic             side;
   logic [1:0]       lane;
   logic [WC_W-1:0]  wcnt;
   logic [WC_W-1:0]  words_q;
   logic [DEV_W-1:0] dev_eff;
   logic             last_word;
   logic             last_lane;
   logic             dly_done;
   logic             word_done;
   logic [DATA_W-1:0] sh_data;
   logic [WORD_W-1:0] word;
   logic             ptr_inc;
   logic             ptr_dec;

   assign fall = dv_q && !dvalid_n;

   always_comb begin
      if (dev_num == '0)                      dev_eff = DEV_W'(1);
      else if (dev_num > DEV_W'(DEV_MAX))     dev_eff = DEV_W'(DEV_MAX);
      else                                    dev_eff = dev_num;
   end

   assign last_word = (wcnt == words_q - WC_W'(1));
   assign last_lane = (lane == 2'(LANES - 1));

   acq_dly_timer #(.DLY_W(DLY_W), .SCLK_DIV(SCLK_DIV)) u_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .start ((state == ST_IDLE) && fall),
      .n_in  (dly_n),
      .done  (dly_done)
   );

   acq_shifter #(.DATA_W(DATA_W)) u_shf (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (state == ST_SHIFT),
      .sdata     (sdata),
      .dclk      (dclk),
      .word_done (word_done),
      .data      (sh_data)
   );

   assign ptr_inc = (state == ST_WRITE) && last_lane;
   assign ptr_dec = !mode_q && dec_req;

   acq_ptr #(.PTR_W(PTR_W)) u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (ptr_inc),
      .dec   (ptr_dec),
      .ptr   (mem_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         dv_q    <= 1'b1;
         mode_q  <= 1'b0;
         side    <= 1'b1;
         xmit_n  <= 1'b1;
         lane    <= '0;
         wcnt    <= '0;
         words_q <= WC_W'(CH_PER_DEV);
      end else begin
         dv_q <= dvalid_n;
         if (state == ST_IDLE || state == ST_DELAY) mode_q <= collect;
         unique case (state)
            ST_IDLE: begin
               if (fall) begin
                  state   <= ST_DELAY;
                  words_q <= WC_W'(dev_eff) * WC_W'(CH_PER_DEV);
               end
            end
            ST_DELAY: begin
               if (dly_done) begin
                  state  <= ST_SHIFT;
                  xmit_n <= 1'b0;
                  wcnt   <= '0;
               end
            end
            ST_SHIFT: begin
               if (word_done) begin
                  if (mode_q) begin
                     state <= ST_WRITE;
                     lane  <= '0;
                  end else if (last_word) begin
                     state  <= ST_IDLE;
                     xmit_n <= 1'b1;
                     side   <= ~side;
                  end else begin
                     wcnt <= wcnt + WC_W'(1);
                  end
               end
            end
            ST_WRITE: begin
               if (last_lane) begin
                  lane <= '0;
                  if (last_word) begin
                     state  <= ST_IDLE;
                     xmit_n <= 1'b1;
                     side   <= ~side;
                  end else begin
                     state <= ST_SHIFT;
                     wcnt  <= wcnt + WC_W'(1);
                  end
               end else begin
                  lane <= lane + 2'd1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      word                 = '0;
      word[DATA_W-1:0]     = sh_data;
      word[SIDE_BIT]       = side;
   end

   assign mem_we    = (state == ST_WRITE);
   assign mem_bsel  = lane;
   assign mem_wdata = word[lane*8 +: 8];
endmodule

// File: rtl/acq_seq_chk.sv
module acq_seq_chk #(
   parameter int PTR_W = 15
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mode_q,
   input logic             dec_req,
   input logic             xmit_n,
   input logic             dclk,
   input logic [PTR_W-1:0] mem_addr,
   input logic [1:0]       mem_bsel,
   input logic             mem_we
);
   a_r6_ptr_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_addr != $past(mem_addr)) |->
         ((mem_addr == $past(mem_addr) + PTR_W'(1)) || (mem_addr == $past(mem_addr) - PTR_W'(1))));

   a_r7_write_only_collect: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mode_q);

   a_r7_collect_ignores_dec: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q && !mem_we) |=> $stable(mem_addr));

   a_r7_readback_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_q && !dec_req) |=> $stable(mem_addr));

   a_r3_dclk_inside_xmit: assert property (@(posedge clk) disable iff (!rst_n)
      dclk |-> !xmit_n);

   a_r5_lane_sequence: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && mem_bsel != 2'd2) |=> (mem_we && mem_bsel == $past(mem_bsel) + 2'd1));

   a_r5_addr_held_in_word: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && mem_bsel != 2'd2) |=> $stable(mem_addr));
endmodule

bind acq_seq acq_seq_chk #(.PTR_W(PTR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mode_q   (mode_q),
   .dec_req  (dec_req),
   .xmit_n   (xmit_n),
   .dclk     (dclk),
   .mem_addr (mem_addr),
   .mem_bsel (mem_bsel),
   .mem_we   (mem_we)
);

// File: tb/acq_seq_test.sv
module acq_seq_test;
   localparam int CLK_PERIOD = 10;
   localparam int DIV        = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        collect = 1'b1;
   logic        dvalid_n = 1'b1;
   logic        sdata = 1'b0;
   logic [8:0]  dly_n = 9'd1;
   logic [6:0]  dev_num = 7'd1;
   logic        dec_req = 1'b0;
   logic        xmit_n;
   logic        dclk;
   logic [14:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic [1:0]  mem_bsel;
   logic        mem_we;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   int idx   = 0;
   int rises = 0;
   int wr_cnt = 0;
   logic        side_exp = 1'b1;
   logic [19:0] conv [0:127];
   logic [23:0] bm [int];

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   acq_seq uut (
      .clk(clk), .rst_n(rst_n), .collect(collect), .dvalid_n(dvalid_n),
      .sdata(sdata), .dly_n(dly_n), .dev_num(dev_num), .dec_req(dec_req),
      .xmit_n(xmit_n), .dclk(dclk), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_bsel(mem_bsel), .mem_we(mem_we)
   );

   // converter model: next bit presented on each rising dclk
   always @(posedge dclk) begin
      if (idx < 2560) sdata = conv[idx / 20][19 - (idx % 20)];
      idx   = idx + 1;
      rises = rises + 1;
   end

   // memory model
   always @(negedge clk) begin
      if (mem_we) begin
         logic [23:0] t;
         t = bm.exists(int'(mem_addr)) ? bm[int'(mem_addr)] : 24'h0;
         t[mem_bsel*8 +: 8] = mem_wdata;
         bm[int'(mem_addr)] = t;
         wr_cnt = wr_cnt + 1;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic run_event(input int dly, input int dev, input bit glitch, output int delta);
      int c0;
      @(negedge clk);
      dly_n   = 9'(dly);
      dev_num = 7'(dev);
      idx     = 0;
      rises   = 0;
      @(negedge clk);
      c0 = cyc;
      dvalid_n = 1'b0;
      while (xmit_n) @(negedge clk);
      delta = cyc - c0;
      if (glitch) begin
         repeat (6) @(negedge clk);
         dvalid_n = 1'b1;
         @(negedge clk);
         dvalid_n = 1'b0;
      end
      while (!xmit_n) @(negedge clk);
      dvalid_n = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic check_words(input int start, input int n, input logic side, input string tag);
      for (int k = 0; k < n; k++) begin
         int a;
         logic [23:0] exp, got;
         a   = (start + k) % 32768;
         exp = {1'b0, side, 2'b00, conv[k]};
         got = bm.exists(a) ? bm[a] : 24'hxxxxxx;
         chk(got === exp, tag, int'(got), int'(exp));
      end
   endtask

   task automatic dec_pulse();
      @(negedge clk);
      dec_req = 1'b1;
      @(negedge clk);
      dec_req = 1'b0;
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk(xmit_n == 1'b1 && dclk == 1'b0 && mem_we == 1'b0, "R1 idle outputs in reset", {xmit_n, dclk, mem_we}, 3'b100);
      rst_n = 1'b1;
      @(negedge clk);
      chk(mem_addr == 15'd0, "R1 address after reset", mem_addr, 0);
      chk(xmit_n == 1'b1, "R1 xmit_n after reset", xmit_n, 1);
   endtask

   task automatic t_first_capture();
      int d, w0;
      conv[0] = 20'hABCDE; conv[1] = 20'h12345;
      w0 = wr_cnt;
      run_event(3, 1, 1'b0, d);
      chk(d == 3*DIV + 1, "R2 delay N=3", d, 3*DIV + 1);
      chk(rises == 40, "R3 one device pulse count", rises, 40);
      check_words(0, 2, 1'b1, "R4 R1 first words side A");
      chk(wr_cnt - w0 == 6, "R5 three byte writes per word", wr_cnt - w0, 6);
      chk(mem_addr == 15'd2, "R5 pointer after two words", mem_addr, 2);
      chk(xmit_n == 1'b1, "R11 xmit_n released", xmit_n, 1);
      side_exp = ~side_exp;
   endtask

   task automatic t_two_devices();
      int d;
      conv[0] = 20'hFFFFF; conv[1] = 20'h00001; conv[2] = 20'h80000; conv[3] = 20'h55555;
      run_event(0, 2, 1'b0, d);
      chk(d == DIV + 1, "R2 delay zero taken as one", d, DIV + 1);
      chk(rises == 80, "R3 two device pulse count", rises, 80);
      check_words(2, 4, 1'b0, "R10 R4 second event side B");
      chk(mem_addr == 15'd6, "R5 pointer after four words", mem_addr, 6);
      side_exp = ~side_exp;
   endtask

   task automatic t_zero_dev_glitch();
      int d;
      conv[0] = 20'h0F0F0; conv[1] = 20'hC3A51;
      run_event(1, 0, 1'b1, d);
      chk(d == DIV + 1, "R2 delay N=1", d, DIV + 1);
      chk(rises == 40, "R3 zero devices taken as one", rises, 40);
      check_words(6, 2, 1'b1, "R10 third event side A");
      chk(mem_addr == 15'd8, "R11 repeated data-ready ignored", mem_addr, 8);
      side_exp = ~side_exp;
      dec_pulse();
      @(negedge clk);
      chk(mem_addr == 15'd8, "R7 dec ignored in collect", mem_addr, 8);
   endtask

   task automatic t_readback();
      int d, w0;
      @(negedge clk);
      collect = 1'b0;
      repeat (2) @(negedge clk);
      for (int k = 0; k < 128; k++) conv[k] = 20'(k * 3 + 1);
      w0 = wr_cnt;
      run_event(2, 100, 1'b0, d);
      chk(rises == 2560, "R3 device count clamped to 64", rises, 2560);
      chk(wr_cnt == w0, "R7 no writes in readback", wr_cnt - w0, 0);
      chk(mem_addr == 15'd8, "R7 pointer idle in readback", mem_addr, 8);
      side_exp = ~side_exp;
      dec_pulse();
      chk(mem_addr == 15'd7, "R7 dec lowers pointer", mem_addr, 7);
      chk(bm[7] == 24'h4C3A51, "R8 newest word first", int'(bm[7]), 24'h4C3A51);
      dec_pulse();
      chk(bm[int'(mem_addr)] == 24'h40F0F0, "R8 next older word", int'(bm[int'(mem_addr)]), 24'h40F0F0);
      for (int k = 0; k < 6; k++) dec_pulse();
      chk(mem_addr == 15'd0, "R8 walked down to zero", mem_addr, 0);
      dec_pulse();
      chk(mem_addr == 15'd32767, "R6 decrement wraps", mem_addr, 32767);
   endtask

   task automatic t_wrap_capture();
      int d;
      @(negedge clk);
      collect = 1'b1;
      repeat (2) @(negedge clk);
      conv[0] = 20'h13579; conv[1] = 20'hFEDCB;
      run_event(1, 1, 1'b0, d);
      check_words(32767, 2, side_exp, "R6 words across wrap");
      chk(mem_addr == 15'd1, "R6 increment wraps", mem_addr, 1);
      side_exp = ~side_exp;
   endtask

   task automatic t_mode_defer();
      int d, w0;
      for (int k = 0; k < 4; k++) conv[k] = 20'(20'h2468A + k);
      w0 = wr_cnt;
      fork
         run_event(1, 2, 1'b0, d);
         begin
            @(negedge xmit_n);
            repeat (4) @(negedge clk);
            collect = 1'b0;
         end
      join
      chk(wr_cnt - w0 == 12, "R9 event finishes storing", wr_cnt - w0, 12);
      check_words(1, 4, side_exp, "R9 deferred words intact");
      chk(mem_addr == 15'd5, "R9 pointer after deferred event", mem_addr, 5);
      side_exp = ~side_exp;
      w0 = wr_cnt;
      run_event(1, 1, 1'b0, d);
      chk(wr_cnt == w0 && mem_addr == 15'd5, "R9 new mode applies next event", wr_cnt - w0, 0);
   endtask

   initial begin
      for (int k = 0; k < 128; k++) conv[k] = '0;
      t_reset();
      t_first_capture();
      t_two_devices();
      t_zero_dev_glitch();
      t_readback();
      t_wrap_capture();
      t_mode_defer();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule